// File: doc/BRIEF.md
# Serial Command/Address Host-Port Slave

This block is a synchronous serial slave through which a host processor reaches a chip's internal registers and memories. The host drives an active-low select, a serial clock and a receive line. The block answers on a transmit line, which it drives only while it is returning read data. The transmit path comes out as a data bit plus an output-enable, so the pad can float whenever the enable is low. Receive and transmit can then share one wire.

Every access opens with a command/address byte. The byte after it is always a data byte: the host sends it on a write, and the block sends it on a read. Both directions move least significant bit first. The block samples the receive line on rising serial-clock edges and changes the transmit bit on falling edges. With select held low, one write may follow another as alternating command and data bytes. After a read, the host must raise select before it starts another access.

All pins are brought into the internal clock domain through synchronizers and an edge detector. The internal side of the block is a plain register port: an address, write data, single-cycle write and read strobes, and a read-data input. Read data is fetched as soon as the command byte completes, so it is loaded before the first transmit edge arrives. For this to work, each half-period of the serial clock must last at least `SYNC_STAGES + 5` internal clock cycles.

Top module: `sermp_slave`

## Requirements
- R1: While reset is asserted and just after it is released, `mp_txd_oe`, `reg_wr` and `reg_rd` are all low.
- R2: The receive line is sampled on each rising serial-clock edge, least significant bit first. The first byte completed after select goes low is decoded as a command/address byte: bits 7:6 hold the operation code and bits 5:0 hold the address.
- R3: Operation code 2'b11 (write) causes the following byte to produce exactly one `reg_wr` pulse, with `reg_addr` equal to the command's address and `reg_wdata` equal to that byte.
- R4: Operation code 2'b10 (read) produces one `reg_rd` pulse with `reg_addr` equal to the command's address. The data then returns on `mp_txd` least significant bit first. Bit 0 is valid from the falling edge that follows the command byte, and each later falling edge moves to the next bit.
- R5: Operation codes 2'b00 and 2'b01 produce no strobe. The byte after such a command is consumed as data, and the byte after that is again a command.
- R6: While select stays low, a command/data write pair may follow another write pair directly, and each pair produces its own write.
- R7: After the data byte of a read, further bytes are ignored until select goes high. They cause no strobe and no transmit enable.
- R8: `mp_txd_oe` is high only while the data byte of a read is being sent. It is low during command bytes, during write data bytes, and once select goes high.
- R9: If select rises partway through a byte, the partial bits are discarded, and the next access after select falls again starts with a command/address byte.
- R10: Serial-clock activity while select is high causes no strobe and no transmit enable.
- R11: `reg_wr` and `reg_rd` each last exactly one internal clock cycle, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mp_cs_n | input | 1 | Active-low select from the host |
| mp_sclk | input | 1 | Serial clock from the host, idle low |
| mp_rxd | input | 1 | Serial data from the host |
| mp_txd | output | 1 | Serial data to the host (valid when enabled) |
| mp_txd_oe | output | 1 | Enable for the transmit pad; low means high impedance |
| reg_addr | output | ADDR_W | Register address of the current access |
| reg_wdata | output | DATA_W | Write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | DATA_W | Read data returned by the register file |

## Verification
A bit counter that drifts shows up at the ports as a write with the wrong address or data. It appears on the very next completed byte, because every later byte is then framed at the wrong offset. A decode state that gets out of step, or that fails to return to command after a select abort or a skipped byte, produces either a missing write or an unexpected one within one byte time. A transmit register that is loaded late or shifted on the wrong edge corrupts the read byte from bit 0 onward, and an enable left high is visible in the first command byte that follows. The bench sweeps every address in both directions, uses both no-op codes, and covers aborts partway through a byte and bytes sent after a read, so each of these faults appears within one transaction.

// File: rtl/sermp_pkg.sv
package sermp_pkg;

   // Decode state for the byte stream of one select-low window
   typedef enum logic [2:0] {
      MP_CMD  = 3'd0,   // expecting a command/address byte
      MP_WR   = 3'd1,   // expecting write data
      MP_RD   = 3'd2,   // read data byte in flight on the transmit line
      MP_SKIP = 3'd3,   // data byte of a no-op command, discarded
      MP_HOLD = 3'd4    // read finished, wait for select to rise
   } mp_state_t;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } mp_op_t;

   function automatic mp_op_t classify_op(input int code, input int rd_code,
                                          input int wr_code);
      if (code == rd_code)      return OP_READ;
      else if (code == wr_code) return OP_WRITE;
      else                      return OP_NONE;
   endfunction

endpackage

// File: rtl/sermp_sync.sv
module sermp_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sermp_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sermp_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sermp_rx.sv
module sermp_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              rxd_s,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_q
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("sermp_rx: DATA_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] sh_nxt;

   // LSB first: each new bit enters at the top and moves down
   assign sh_nxt = {rxd_s, sh[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sh       <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (!cs_act) begin
            cnt <= '0;
            sh  <= '0;
         end else if (sclk_rise) begin
            sh <= sh_nxt;
            if (cnt == LAST_BIT) begin
               cnt      <= '0;
               byte_vld <= 1'b1;
               byte_q   <= sh_nxt;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R9: a deselected port forgets its partial byte
   a_r9_cnt_clear : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (cnt == '0) && !byte_vld);

   // R2: one completed byte gives one single-cycle pulse
   a_r2_byte_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

endmodule

// File: rtl/sermp_tx.sv
module sermp_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              sclk_fall,
   input  logic              stop,
   output logic              txd_bit,
   output logic              txd_oe
);

   logic [DATA_W-1:0] sh;
   logic              armed;
   logic              active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         armed  <= 1'b0;
         active <= 1'b0;
      end else if (stop) begin
         armed  <= 1'b0;
         active <= 1'b0;
      end else if (load) begin
         sh     <= ld_data;
         armed  <= 1'b1;
         active <= 1'b0;
      end else if (sclk_fall) begin
         if (active) begin
            sh <= {1'b0, sh[DATA_W-1:1]};
         end else if (armed) begin
            // first falling edge presents bit 0 without shifting
            active <= 1'b1;
            armed  <= 1'b0;
         end
      end
   end

   assign txd_bit = sh[0];
   assign txd_oe  = active;

   // R8: the driver turns on only at a falling serial-clock edge
   a_r8_oe_on_fall : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(sclk_fall));

   // R4: the transmitted bit moves only on a falling edge
   a_r4_hold_between_falls : assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$past(sclk_fall) && !$past(load) && !$past(stop))
         |-> $stable(sh));

endmodule

// File: rtl/sermp_slave.sv
module sermp_slave
   import sermp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int RD_LATENCY  = 1,
   parameter int RD_CODE     = 2,
   parameter int WR_CODE     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mp_cs_n,
   input  logic              mp_sclk,
   input  logic              mp_rxd,
   output logic              mp_txd,
   output logic              mp_txd_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int CMD_W = DATA_W - ADDR_W;

   generate
      if (ADDR_W < 1 || CMD_W < 1) begin : g_bad_split
         $error("sermp_slave: ADDR_W must leave at least one command bit");
      end
      if (RD_CODE == WR_CODE) begin : g_bad_codes
         $error("sermp_slave: read and write codes must differ");
      end
      if (RD_LATENCY < 0 || RD_LATENCY > 1) begin : g_bad_lat
         $error("sermp_slave: RD_LATENCY must be 0 or 1");
      end
   endgenerate

   // ---------------- pin synchronization and edge detection -------------
   logic cs_s, sclk_s, rxd_s;
   logic sclk_q;
   logic cs_act, sclk_rise, sclk_fall;

   sermp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mp_cs_n, mp_sclk, mp_rxd}),
      .q     ({cs_s, sclk_s, rxd_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign cs_act    = !cs_s;
   assign sclk_rise = sclk_s && !sclk_q;
   assign sclk_fall = !sclk_s && sclk_q;

   // ---------------- receive shifter ------------------------------------
   logic              byte_vld;
   logic [DATA_W-1:0] byte_q;

   sermp_rx #(.DATA_W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sclk_rise (sclk_rise),
      .rxd_s     (rxd_s),
      .byte_vld  (byte_vld),
      .byte_q    (byte_q)
   );

   // ---------------- command decode and strobes -------------------------
   mp_state_t st;
   mp_op_t    op;

   assign op = classify_op(int'(byte_q[DATA_W-1 -: CMD_W]), RD_CODE, WR_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= MP_CMD;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         if (!cs_act) begin
            st <= MP_CMD;
         end else if (byte_vld) begin
            unique case (st)
               MP_CMD: begin
                  reg_addr <= byte_q[ADDR_W-1:0];
                  unique case (op)
                     OP_READ: begin
                        reg_rd <= 1'b1;
                        st     <= MP_RD;
                     end
                     OP_WRITE: st <= MP_WR;
                     default:  st <= MP_SKIP;
                  endcase
               end
               MP_WR: begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= byte_q;
                  st        <= MP_CMD;
               end
               MP_SKIP: st <= MP_CMD;
               MP_RD:   st <= MP_HOLD;
               default: st <= MP_HOLD;
            endcase
         end
      end
   end

   // ---------------- read data capture ----------------------------------
   logic tx_load;
   logic tx_stop;

   generate
      if (RD_LATENCY == 0) begin : g_rd_comb
         assign tx_load = reg_rd;
      end else begin : g_rd_reg
         logic rd_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_d <= 1'b0;
            else        rd_d <= reg_rd && cs_act;
         end
         assign tx_load = rd_d;
      end
   endgenerate

   assign tx_stop = !cs_act || (st == MP_RD && byte_vld) || (st != MP_RD);

   sermp_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .ld_data   (reg_rdata),
      .sclk_fall (sclk_fall),
      .stop      (tx_stop),
      .txd_bit   (mp_txd),
      .txd_oe    (mp_txd_oe)
   );

   // ---------------- assertions -----------------------------------------
   a_r11_strobe_excl : assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   a_r11_wr_single : assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   a_r11_rd_single : assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   a_r3_wr_after_data : assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> ($past(st) == MP_WR) && $past(byte_vld));

   a_r4_rd_after_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> ($past(st) == MP_CMD) && $past(byte_vld));

   a_r9_restart_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (st == MP_CMD));

   a_r8_oe_needs_cs : assert property (@(posedge clk) disable iff (!rst_n)
      mp_txd_oe |-> $past(cs_act));

   a_r8_oe_read_only : assert property (@(posedge clk) disable iff (!rst_n)
      mp_txd_oe |-> (st == MP_RD));

   a_r7_hold_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (st == MP_HOLD) |-> !reg_wr && !reg_rd && !mp_txd_oe);

endmodule

// File: tb/sermp_slave_tb_top.sv
module sermp_slave_tb_top;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       rxd = 1'b0;
   logic       txd, txd_oe;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata;
   logic       reg_wr, reg_rd;
   logic [7:0] reg_rdata;

   int checks = 0;
   int failures = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int both_cnt = 0;
   logic [5:0] last_wa, last_ra;
   logic [7:0] last_wd;
   bit done = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] rd_val(input logic [5:0] a);
      return 8'((int'(a) * 37 + 11) % 256);
   endfunction

   function automatic logic [7:0] wr_val(input logic [5:0] a);
      return 8'((int'(a) * 5 + 163) % 256);
   endfunction

   assign reg_rdata = rd_val(reg_addr);

   sermp_slave dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mp_cs_n   (cs_n),
      .mp_sclk   (sclk),
      .mp_rxd    (rxd),
      .mp_txd    (txd),
      .mp_txd_oe (txd_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   always @(posedge clk) begin
      if (reg_wr) begin
         wr_cnt++;
         last_wa = reg_addr;
         last_wd = reg_wdata;
      end
      if (reg_rd) begin
         rd_cnt++;
         last_ra = reg_addr;
      end
      if (reg_wr && reg_rd) both_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial clock period: drive rxd, sample txd just before the rise
   task automatic sbit(input logic din, output logic dout, output logic oe);
      @(negedge clk);
      rxd = din;
      wait_clk(HALF);
      dout = txd;
      oe   = txd_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n,
                            output logic [7:0] got, output bit oe_all, output bit oe_any);
      logic d, o;
      got = '0;
      oe_all = 1;
      oe_any = 0;
      for (int i = 0; i < n; i++) begin
         sbit(b[i], d, o);
         got[i] = d;
         if (!o) oe_all = 0;
         if (o)  oe_any = 1;
      end
   endtask

   task automatic cs_low();
      @(negedge clk);
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_high();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic write_pair(input logic [5:0] a, input logic [7:0] d, output bit oe_any);
      logic [7:0] g;
      bit oa, o1, o2;
      send_bits({2'b11, a}, 8, g, oa, o1);
      send_bits(d, 8, g, oa, o2);
      oe_any = o1 | o2;
   endtask

   initial begin
      int w0, r0;
      logic [7:0] g;
      bit oa, oy, oy2;

      wait_clk(4);
      // R1: outputs quiet in reset
      chk(txd_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1 reset idle",
          {txd_oe, reg_wr, reg_rd}, 0);
      rst_n = 1'b1;
      wait_clk(6);
      chk(txd_oe == 0 && wr_cnt == 0 && rd_cnt == 0, "R1 after reset",
          {txd_oe, reg_wr, reg_rd}, 0);

      // R3 R6 R2: every address written, two writes per select window
      for (int a = 0; a < 64; a += 2) begin
         cs_low();
         w0 = wr_cnt;
         write_pair(6'(a), wr_val(6'(a)), oy);
         chk(wr_cnt == w0 + 1 && last_wa == 6'(a) && last_wd == wr_val(6'(a)),
             "R3 write addr/data", int'(last_wd), int'(wr_val(6'(a))));
         write_pair(6'(a + 1), wr_val(6'(a + 1)), oy2);
         chk(wr_cnt == w0 + 2 && last_wa == 6'(a + 1) && last_wd == wr_val(6'(a + 1)),
             "R6 back-to-back write", int'(last_wa), a + 1);
         chk(!oy && !oy2, "R8 no oe during writes", int'(oy | oy2), 0);
         cs_high();
      end

      // R4 R7 R8: every address read
      for (int a = 0; a < 64; a++) begin
         cs_low();
         r0 = rd_cnt;
         w0 = wr_cnt;
         send_bits({2'b10, 6'(a)}, 8, g, oa, oy);
         chk(!oy, "R8 no oe during command", int'(oy), 0);
         send_bits(8'h00, 8, g, oa, oy);
         chk(g == rd_val(6'(a)), "R4 read data LSB first", int'(g), int'(rd_val(6'(a))));
         chk(oa && rd_cnt == r0 + 1 && last_ra == 6'(a), "R4 read strobe and oe",
             rd_cnt - r0, 1);
         wait_clk(4);
         chk(txd_oe == 0, "R8 oe off after read byte", int'(txd_oe), 0);
         if (a % 8 == 0) begin
            write_pair(6'(a), 8'h5A, oy);
            chk(wr_cnt == w0 && rd_cnt == r0 + 1 && !oy, "R7 bytes after read ignored",
                wr_cnt - w0, 0);
         end
         cs_high();
         chk(txd_oe == 0, "R8 oe off when deselected", int'(txd_oe), 0);
      end

      // R5: both no-op codes consume a data byte
      for (int c = 0; c < 2; c++) begin
         cs_low();
         w0 = wr_cnt;
         r0 = rd_cnt;
         send_bits({2'(c), 6'd9}, 8, g, oa, oy);
         send_bits({2'b11, 6'd33}, 8, g, oa, oy2);
         chk(wr_cnt == w0 && rd_cnt == r0 && !oy && !oy2, "R5 no-op no strobe",
             wr_cnt - w0 + rd_cnt - r0, 0);
         write_pair(6'd20 + 6'(c), 8'hC3 ^ 8'(c), oy);
         chk(wr_cnt == w0 + 1 && last_wa == 6'd20 + 6'(c) && last_wd == (8'hC3 ^ 8'(c)),
             "R5 command after skipped byte", int'(last_wa), 20 + c);
         cs_high();
      end

      // R9: select rises partway through a byte
      for (int n = 1; n < 8; n += 3) begin
         cs_low();
         w0 = wr_cnt;
         send_bits(8'hFF, n, g, oa, oy);
         cs_high();
         cs_low();
         write_pair(6'd45, 8'(n * 17), oy);
         chk(wr_cnt == w0 + 1 && last_wa == 6'd45 && last_wd == 8'(n * 17),
             "R9 abort discards partial byte", int'(last_wd), n * 17);
         cs_high();
      end
      // R9: abort partway through a write data byte
      cs_low();
      w0 = wr_cnt;
      send_bits({2'b11, 6'd7}, 8, g, oa, oy);
      send_bits(8'h77, 4, g, oa, oy);
      cs_high();
      chk(wr_cnt == w0, "R9 aborted data byte not written", wr_cnt - w0, 0);

      // R10: clocks with select high do nothing
      w0 = wr_cnt;
      r0 = rd_cnt;
      write_pair(6'd3, 8'h3C, oy);
      send_bits({2'b10, 6'd3}, 8, g, oa, oy2);
      send_bits(8'h00, 8, g, oa, oy2);
      chk(wr_cnt == w0 && rd_cnt == r0 && !oy && !oy2, "R10 deselected clocks ignored",
          wr_cnt - w0 + rd_cnt - r0, 0);

      // R11: strobes never overlap
      chk(both_cnt == 0, "R11 strobes exclusive", both_cnt, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule